// File: doc/BRIEF.md
# Reset Sequencer with Boot Strap Capture

This block orders reset for a small microcontroller core. An external active-low reset pin and an internal reset request can each start a reset. The block then turns on an open-drain pull-down on the reset pin for a fixed number of state times. A configuration input can keep internal resets off the pin while the core is still reset. The core reset output stays high until the stretch has ended and the synchronised pin reads high again.

On the release edge of the reset pin, the block latches two active-low strap pins. One strap selects pin isolation for an external emulator, which puts every pad except the crystal pair into high impedance. The other strap selects a reserved test mode. Isolation can only be left by pulling the reset pin low again. A reset event that arrives while the core sleeps in idle or powerdown raises a pulse that returns the power-mode logic to normal operation. The block also gives the fixed fetch address for the first instruction after reset, and a one-cycle pulse when the core leaves reset.

Top module: `rst_boot_ctrl`

## Requirements
- R1: A falling edge of the synchronised reset pin, seen while the pull-down is idle, drives `pin_pull_en` high for exactly STRETCH_TICKS (default 16) `st_tick` pulses. It goes low on the clock edge that takes the last of those pulses.
- R2: A high `int_rst_req` while the pull-down is idle, with `keep_int_off_pin` = 0, drives `pin_pull_en` high for exactly STRETCH_TICKS `st_tick` pulses.
- R3: With `keep_int_off_pin` = 1, an internal request asserts `core_rst` for the stretch and leaves `pin_pull_en` low the whole time.
- R4: A falling edge or internal request that arrives while the pull-down is active neither restarts nor lengthens the stretch.
- R5: `core_rst` is high while a stretch is running and while the synchronised reset pin is low. It falls only when both have ended.
- R6: At a rising edge of the synchronised reset pin, `pad_hiz` becomes 1 if `emu_strap_n` is 0 and becomes 0 if it is 1.
- R7: Once latched, `pad_hiz` ignores later changes of `emu_strap_n`. It is cleared only by a falling edge of the synchronised reset pin, so an internal reset kept off the pin leaves it unchanged.
- R8: At a rising edge of the synchronised reset pin, `test_mode` becomes 1 if `tst_strap_n` is 0 and becomes 0 if it is 1. It holds that value between such edges.
- R9: A reset event (accepted falling edge or accepted internal request) while `lowpwr_active` is 1 gives a one-cycle `wake_normal` pulse, and `core_rst` is high in that cycle.
- R10: `fetch_addr` always reads 0x2080. `fetch_go` pulses for exactly one cycle, in the cycle in which `core_rst` has just fallen.
- R11: While and right after `rst` is high, `core_rst` = 1, `pin_pull_en` = 0, `pad_hiz` = 0, `test_mode` = 0 and `wake_normal` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| st_tick | input | 1 | One pulse per state time |
| rst_pin_n | input | 1 | Level read back from the reset pin |
| int_rst_req | input | 1 | Internal reset request (watchdog, instruction and similar sources) |
| keep_int_off_pin | input | 1 | 1: internal resets do not drive the pin |
| emu_strap_n | input | 1 | Active-low emulation-isolation strap |
| tst_strap_n | input | 1 | Active-low test-mode strap |
| lowpwr_active | input | 1 | Core is in idle or powerdown |
| pin_pull_en | output | 1 | Enable for the open-drain pull-down on the reset pin |
| core_rst | output | 1 | Active-high reset for the core |
| pad_hiz | output | 1 | Put all pads except the crystal pair in high impedance |
| test_mode | output | 1 | Reserved test mode selected |
| wake_normal | output | 1 | Pulse that forces the power mode back to normal |
| fetch_addr | output | ADDR_W | Address of the first fetch after reset |
| fetch_go | output | 1 | One-cycle pulse when the core leaves reset |

## Verification
Two things can land in the same cycle: an internal request and the pin's falling edge. This includes the edge the block causes itself when its pull-down drags the pin low. The bench drives the pin through an open-drain model and sends internal requests in the middle of a running stretch. It counts the `st_tick` pulses seen while `pin_pull_en` is high and expects exactly STRETCH_TICKS across several tick periods. A strap release also falls close to the point where the stretch expires. The bench judges this by reading `pad_hiz` and `test_mode` after `core_rst` falls, against the strap levels it applied.

// File: rtl/rst_boot_pkg.sv
package rst_boot_pkg;
  typedef struct packed {
    logic emu_iso;
    logic tst_on;
  } strap_t;

  localparam strap_t STRAP_RESET = '{emu_iso: 1'b0, tst_on: 1'b0};
endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic level,
  output logic fall,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b1;
          else     chain[g] <= pin_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b1;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last <= 1'b1;
    else     last <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign fall  = last & ~chain[STAGES-1];
  assign rise  = ~last & chain[STAGES-1];
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
  parameter int TICKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic ext_fall,
  input  logic int_req,
  input  logic keep_off,
  output logic active,
  output logic drive,
  output logic accept
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;
  logic          start_ext;
  logic          start_int;

  assign start_ext = ext_fall & ~active;
  assign start_int = int_req & ~active;
  assign accept    = start_ext | start_int;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      drive  <= 1'b0;
      cnt    <= '0;
    end else if (accept) begin
      active <= 1'b1;
      drive  <= start_ext | ~keep_off;
      cnt    <= '0;
    end else if (active && tick) begin
      if (cnt == LAST) begin
        active <= 1'b0;
        drive  <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/strap_latch.sv
module strap_latch
  import rst_boot_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   rel_edge,
  input  logic   asrt_edge,
  input  logic   emu_n,
  input  logic   tst_n,
  output strap_t straps
);
  always_ff @(posedge clk) begin
    if (rst) begin
      straps <= STRAP_RESET;
    end else if (rel_edge) begin
      straps.emu_iso <= ~emu_n;
      straps.tst_on  <= ~tst_n;
    end else if (asrt_edge) begin
      straps.emu_iso <= 1'b0;
    end
  end
endmodule

// File: rtl/rst_boot_ctrl.sv
module rst_boot_ctrl
  import rst_boot_pkg::*;
#(
  parameter int          STRETCH_TICKS = 16,
  parameter int          SYNC_STAGES   = 2,
  parameter int          ADDR_W        = 16,
  parameter logic [15:0] BOOT_ADDR     = 16'h2080
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_tick,
  input  logic              rst_pin_n,
  input  logic              int_rst_req,
  input  logic              keep_int_off_pin,
  input  logic              emu_strap_n,
  input  logic              tst_strap_n,
  input  logic              lowpwr_active,
  output logic              pin_pull_en,
  output logic              core_rst,
  output logic              pad_hiz,
  output logic              test_mode,
  output logic              wake_normal,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_go
);
  logic   pin_lvl, pin_fall, pin_rise;
  logic   st_active, st_drive, st_accept;
  logic   core_next;
  strap_t straps;

  rst_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pin_n (rst_pin_n),
    .level (pin_lvl),
    .fall  (pin_fall),
    .rise  (pin_rise)
  );

  rst_stretch #(.TICKS(STRETCH_TICKS)) u_stretch (
    .clk      (clk),
    .rst      (rst),
    .tick     (st_tick),
    .ext_fall (pin_fall),
    .int_req  (int_rst_req),
    .keep_off (keep_int_off_pin),
    .active   (st_active),
    .drive    (st_drive),
    .accept   (st_accept)
  );

  strap_latch u_strap (
    .clk       (clk),
    .rst       (rst),
    .rel_edge  (pin_rise),
    .asrt_edge (pin_fall),
    .emu_n     (emu_strap_n),
    .tst_n     (tst_strap_n),
    .straps    (straps)
  );

  assign core_next = st_accept | st_active | ~pin_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      core_rst    <= 1'b1;
      wake_normal <= 1'b0;
      fetch_go    <= 1'b0;
      fetch_addr  <= ADDR_W'(BOOT_ADDR);
    end else begin
      core_rst    <= core_next;
      wake_normal <= st_accept & lowpwr_active;
      fetch_go    <= core_rst & ~core_next;
      fetch_addr  <= ADDR_W'(BOOT_ADDR);
    end
  end

  assign pin_pull_en = st_active & st_drive;
  assign pad_hiz     = straps.emu_iso;
  assign test_mode   = straps.tst_on;
endmodule

// File: rtl/rst_boot_chk.sv
module rst_boot_chk (
  input logic clk,
  input logic rst,
  input logic st_tick,
  input logic keep_int_off_pin,
  input logic pin_fall,
  input logic pin_rise,
  input logic pin_pull_en,
  input logic core_rst,
  input logic pad_hiz,
  input logic test_mode,
  input logic wake_normal,
  input logic fetch_go
);
  // R1: the pull-down only ends on a state-time tick
  a_r1_end_on_tick: assert property (@(posedge clk) disable iff (rst)
    $fell(pin_pull_en) |-> $past(st_tick));

  // R3: with the pin kept out, only an external edge may start the pull-down
  a_r3_keep_off: assert property (@(posedge clk) disable iff (rst)
    $rose(pin_pull_en) |-> (!$past(keep_int_off_pin) || $past(pin_fall)));

  // R5: core reset covers the whole pull-down
  a_r5_core_covers: assert property (@(posedge clk) disable iff (rst)
    pin_pull_en |-> core_rst);

  // R7: isolation only moves on a pin edge
  a_r7_iso_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(pin_rise) && !$past(pin_fall)) |-> $stable(pad_hiz));

  // R8: test mode only moves on a release edge
  a_r8_tst_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(pin_rise) |-> $stable(test_mode));

  // R9: wake pulse only during reset
  a_r9_wake_in_rst: assert property (@(posedge clk) disable iff (rst)
    wake_normal |-> core_rst);

  // R10: fetch pulse exactly where core reset has fallen
  a_r10_go_edge: assert property (@(posedge clk) disable iff (rst)
    fetch_go |-> ($past(core_rst) && !core_rst));
endmodule

bind rst_boot_ctrl rst_boot_chk u_chk (
  .clk              (clk),
  .rst              (rst),
  .st_tick          (st_tick),
  .keep_int_off_pin (keep_int_off_pin),
  .pin_fall         (pin_fall),
  .pin_rise         (pin_rise),
  .pin_pull_en      (pin_pull_en),
  .core_rst         (core_rst),
  .pad_hiz          (pad_hiz),
  .test_mode        (test_mode),
  .wake_normal      (wake_normal),
  .fetch_go         (fetch_go)
);

// File: tb/rst_boot_ctrl_tb.sv
`timescale 1ns/1ps
module rst_boot_ctrl_tb;
  localparam int TICKS = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic st_tick = 1'b0;
  logic ext_drv_n = 1'b1;
  logic int_rst_req = 1'b0;
  logic keep_int_off_pin = 1'b0;
  logic emu_strap_n = 1'b1;
  logic tst_strap_n = 1'b1;
  logic lowpwr_active = 1'b0;
  logic pin_pull_en, core_rst, pad_hiz, test_mode, wake_normal, fetch_go;
  logic [15:0] fetch_addr;
  logic rst_pin_n;

  assign rst_pin_n = ext_drv_n & ~pin_pull_en;

  always #2 clk = ~clk;

  rst_boot_ctrl u_dut (
    .clk(clk), .rst(rst), .st_tick(st_tick), .rst_pin_n(rst_pin_n),
    .int_rst_req(int_rst_req), .keep_int_off_pin(keep_int_off_pin),
    .emu_strap_n(emu_strap_n), .tst_strap_n(tst_strap_n),
    .lowpwr_active(lowpwr_active), .pin_pull_en(pin_pull_en),
    .core_rst(core_rst), .pad_hiz(pad_hiz), .test_mode(test_mode),
    .wake_normal(wake_normal), .fetch_addr(fetch_addr), .fetch_go(fetch_go)
  );

  int checks = 0, errors = 0;
  int period = 1, phase = 0, cycles = 0;
  int run_ticks = 0, last_run = -1, runs = 0;
  int pd_seen = 0, wake_seen = 0, go_seen = 0, go_bad = 0;
  logic prev_core = 1'b1;
  logic prev_pd = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // tick generator and monitors (sampled mid-cycle)
  always @(negedge clk) begin
    cycles++;
    if (prev_pd && !pin_pull_en) begin last_run = run_ticks; runs++; end
    if (pin_pull_en && !prev_pd) run_ticks = 0;
    if (pin_pull_en) pd_seen++;
    if (wake_normal) begin
      wake_seen++;
      if (!core_rst) go_bad++;
    end
    if (fetch_go) begin
      go_seen++;
      if (!(prev_core && !core_rst)) go_bad++;
    end
    prev_pd = pin_pull_en;
    prev_core = core_rst;
    st_tick <= (phase == period - 1);
    phase = (phase + 1 >= period) ? 0 : phase + 1;
    if (pin_pull_en && (phase == 0)) run_ticks++;
  end

  // count ticks applied in cycles where pull-down is active:
  // st_tick set at negedge now is taken at next posedge; the counter above
  // increments when the tick just scheduled (phase wrapped to 0) falls in a
  // cycle whose pull-down level is high.

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic clear_mon();
    pd_seen = 0; wake_seen = 0; go_seen = 0; go_bad = 0; runs = 0; last_run = -1;
  endtask

  task automatic wait_release();
    int n = 0;
    while (!core_rst && n < 200) begin @(negedge clk); n++; end
    n = 0;
    while (core_rst && n < 2000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic ext_reset(input int hold, input logic emu, input logic tst);
    @(negedge clk);
    emu_strap_n = emu; tst_strap_n = tst;
    ext_drv_n = 1'b0;
    repeat (hold) @(negedge clk);
    ext_drv_n = 1'b1;
    wait_release();
  endtask

  task automatic int_reset(input logic keep);
    @(negedge clk);
    keep_int_off_pin = keep;
    int_rst_req = 1'b1;
    @(negedge clk);
    int_rst_req = 1'b0;
    wait_release();
    keep_int_off_pin = 1'b0;
  endtask

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11 core_rst", core_rst, 1);
    chk("R11 pin_pull_en", pin_pull_en, 0);
    chk("R11 pad_hiz", pad_hiz, 0);
    chk("R11 test_mode", test_mode, 0);
    chk("R11 wake_normal", wake_normal, 0);
    rst = 1'b0;
    repeat (8) @(negedge clk);
    chk("R10 fetch_addr", fetch_addr, 16'h2080);

    for (int p = 1; p <= 3; p++) begin
      period = p;
      for (int s = 0; s < 4; s++) begin
        logic e_n, t_n;
        e_n = s[0]; t_n = s[1];
        clear_mon();
        lowpwr_active = s[0] ^ s[1];
        ext_reset(3, e_n, t_n);
        lowpwr_active = 1'b0;
        chk("R1 stretch ticks ext", last_run, TICKS);
        chk("R6 pad_hiz", pad_hiz, !e_n);
        chk("R8 test_mode", test_mode, !t_n);
        chk("R9 wake pulses", wake_seen, (s[0] ^ s[1]) ? 1 : 0);
        chk("R10 fetch_go count", go_seen, 1);
        chk("R10 fetch_go placement", go_bad, 0);
        chk("R10 fetch_addr", fetch_addr, 16'h2080);
      end

      // R7: isolated, strap toggles without reset have no effect
      ext_reset(2, 1'b0, 1'b1);
      emu_strap_n = 1'b1;
      tst_strap_n = 1'b0;
      repeat (30) @(negedge clk);
      chk("R7 iso holds after strap change", pad_hiz, 1);
      chk("R8 test holds after strap change", test_mode, 0);

      // R3: internal reset kept off the pin keeps isolation and pin idle
      clear_mon();
      int_reset(1'b1);
      chk("R3 no pull-down", pd_seen, 0);
      chk("R3 core reset pulsed", go_seen, 1);
      chk("R7 iso kept by off-pin reset", pad_hiz, 1);

      // R2: internal reset on the pin, strap now high -> isolation cleared
      clear_mon();
      int_reset(1'b0);
      chk("R2 stretch ticks int", last_run, TICKS);
      chk("R7 iso re-sampled", pad_hiz, 0);
      chk("R8 test re-sampled", test_mode, 1);

      // R4: requests during an active stretch do not extend it
      clear_mon();
      @(negedge clk);
      ext_drv_n = 1'b0;
      @(negedge clk);
      ext_drv_n = 1'b1;
      repeat (6) @(negedge clk);
      int_rst_req = 1'b1;
      repeat (2) @(negedge clk);
      int_rst_req = 1'b0;
      repeat (3 * p) @(negedge clk);
      ext_drv_n = 1'b0;
      @(negedge clk);
      ext_drv_n = 1'b1;
      wait_release();
      chk("R4 no retrigger ticks", last_run, TICKS);
      chk("R4 single stretch", runs, 1);

      // R5: core reset held while pin held low past stretch
      clear_mon();
      @(negedge clk);
      ext_drv_n = 1'b0;
      repeat (TICKS * p + 40) @(negedge clk);
      chk("R5 stretch over", pin_pull_en, 0);
      chk("R5 core_rst while pin low", core_rst, 1);
      ext_drv_n = 1'b1;
      wait_release();
      chk("R5 core_rst released", core_rst, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule